// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block drives the horizontal sync, vertical sync, data-enable and start-of-frame signals of a parallel RGB panel. Software programs the sync pulse widths, the porches on both axes, the active size, the sync polarities, the output packing and the pixel clock divider setting through a small word-addressed register port. The block computes no divider ratio and fetches no pixels. It only forwards the divider value and its source selection to the clock logic, and the packing code to the pixel path.

Every horizontal and vertical timing field is stored as its length minus one, with one exception: the vertical back porch is stored as the plain line count and may therefore be zero. Power-up runs through three stages in a fixed order: pixel clock, then sync, then display. A power state machine has the states PWR_OFF, PWR_CLK, PWR_SYNC and PWR_DISP. It moves one state per cycle, either up (OFF to CLK, CLK to SYNC, SYNC to DISP) or down (DISP to SYNC, SYNC to CLK, CLK to OFF). It moves up when the request bit of the next stage is set and moves down when the request bit of the current top stage is clear. A write-one-to-set enable register and a write-one-to-clear disable register change the request bits. The state appears as three status bits. Each start of frame sets an interrupt status bit, which a write-one enable register and a write-one disable register can mask.

Top module: `lcd_sync_timing_gen`

## Requirements
- R1: After reset, the status register, interrupt mask and interrupt status read 0. hsync, vsync, data-enable, frame_start and irq are low. The divider output is 2.
- R2: Register layout. Address 1 holds the hsync width minus 1 at [15:0] and the vsync width minus 1 at [31:16]. Address 2 holds the vertical front porch minus 1 at [15:0] and the vertical back porch as a plain count at [31:16]. Address 3 holds the horizontal front porch minus 1 at [15:0] and the horizontal back porch minus 1 at [31:16]. Address 4 holds the active width minus 1 at [15:0] and the active height minus 1 at [31:16]. Each field keeps its low 12 bits and reads back as written.
- R3: While sync runs, each line is sync, back porch, active, front porch, one pixel per clock. Each frame is sync lines, back-porch lines, active lines, front-porch lines. hsync is active during the sync pixels of every line. vsync is active during the whole of the sync lines.
- R4: Data-enable is high only on active pixels of active lines, only while the display stage is on, and never together with an active hsync.
- R5: The enable register (address 6) takes bit0 pixel clock, bit1 sync and bit2 display. A stage's status bit (address 8, same positions) reads 1 in the cycle after its request, provided the stage below it is already up. Otherwise the stage waits and comes up one cycle after the stage below it. At most one stage changes per cycle.
- R6: The disable register (address 7) clears requests at the same bit positions. Stages come down in the order display, sync, pixel clock. A stage whose request is cleared stays up while the stage above it is still up.
- R7: Address 5 bit0 makes hsync active-low and bit1 makes vsync active-low. When sync is off, both pins rest at their inactive level.
- R8: frame_start is high for exactly one clock, on the first pixel of the first sync line. This includes the cycle in which the sync status first reads 1.
- R9: A frame start sets interrupt status bit0 (address 12, cleared by writing 1). Writing 1 to address 9 sets mask bit0 and writing 1 to address 10 clears it; the mask reads at address 11. irq equals status AND mask, one cycle after the frame start.
- R10: Address 0 bit0 selects the doubled-rate divider source and bits [15:8] hold the divider. A written divider below 2 is stored as 2. Address 5 bits [9:8] drive out_mode (0 RGB444, 1 RGB565, 2 RGB666, 3 RGB888).
- R11: When sync is off, frame_start and data-enable are low. Re-enabling sync restarts the frame at pixel 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| lcd_hsync | output | 1 | Horizontal sync, programmable polarity |
| lcd_vsync | output | 1 | Vertical sync, programmable polarity |
| lcd_de | output | 1 | Data-enable for active pixels |
| frame_start | output | 1 | One-clock start-of-frame pulse |
| irq | output | 1 | Masked start-of-frame interrupt |
| pclk_div | output | 8 | Pixel clock divider value, never below 2 |
| pclk_src_2x | output | 1 | Divider source select, 1 for the doubled-rate clock |
| out_mode | output | 2 | RGB packing code |

## Verification
A write takes effect at the clock edge that ends its write cycle. Register contents, the divider output and status changes therefore appear in the sample taken half a clock later. A stage that is waiting on a lower stage shows up one sample after that lower stage. The bench reads status in those same samples, so it sees each step of a cascade separately.

Sync and data-enable are combinational functions of the pixel and line counters. Each one is compared every cycle against a counter model indexed from the cycle where frame_start is seen. irq follows frame_start by exactly one cycle, and the bench samples it at the next falling edge.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

    typedef enum logic [1:0] {
        PWR_OFF  = 2'd0,
        PWR_CLK  = 2'd1,
        PWR_SYNC = 2'd2,
        PWR_DISP = 2'd3
    } pwr_state_t;

    localparam int STG_PCLK = 0;
    localparam int STG_SYNC = 1;
    localparam int STG_DISP = 2;
    localparam int NUM_STG  = 3;

    localparam logic [3:0] A_CLKCFG = 4'd0;
    localparam logic [3:0] A_SYNCW  = 4'd1;
    localparam logic [3:0] A_VPORCH = 4'd2;
    localparam logic [3:0] A_HPORCH = 4'd3;
    localparam logic [3:0] A_ACTIVE = 4'd4;
    localparam logic [3:0] A_POLMOD = 4'd5;
    localparam logic [3:0] A_EN     = 4'd6;
    localparam logic [3:0] A_DIS    = 4'd7;
    localparam logic [3:0] A_STAT   = 4'd8;
    localparam logic [3:0] A_IEN    = 4'd9;
    localparam logic [3:0] A_IDIS   = 4'd10;
    localparam logic [3:0] A_IMASK  = 4'd11;
    localparam logic [3:0] A_ISR    = 4'd12;

endpackage

// File: rtl/lcd_tg_power.sv
module lcd_tg_power
    import lcd_tg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_STG-1:0] set_req,
    input  logic [NUM_STG-1:0] clr_req,
    output logic [NUM_STG-1:0] status
);

    logic [NUM_STG-1:0] req_q;
    logic [NUM_STG-1:0] req_d;
    pwr_state_t         state_q;
    pwr_state_t         state_d;

    assign req_d = (req_q | set_req) & ~clr_req;

    // state register and request register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= '0;
            state_q <= PWR_OFF;
        end else begin
            req_q   <= req_d;
            state_q <= state_d;
        end
    end

    // next-state: one step per cycle, down takes precedence over up
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_OFF: begin
                if (req_d[STG_PCLK]) state_d = PWR_CLK;
            end
            PWR_CLK: begin
                if (!req_d[STG_PCLK])     state_d = PWR_OFF;
                else if (req_d[STG_SYNC]) state_d = PWR_SYNC;
            end
            PWR_SYNC: begin
                if (!req_d[STG_SYNC])     state_d = PWR_CLK;
                else if (req_d[STG_DISP]) state_d = PWR_DISP;
            end
            PWR_DISP: begin
                if (!req_d[STG_DISP]) state_d = PWR_SYNC;
            end
        endcase
    end

    // outputs
    always_comb begin
        status = '0;
        unique case (state_q)
            PWR_OFF:  status = 3'b000;
            PWR_CLK:  status = 3'b001;
            PWR_SYNC: status = 3'b011;
            PWR_DISP: status = 3'b111;
        endcase
    end

    a_r5_one_stage_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status ^ $past(status)) <= 1);

    a_r5_disp_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[STG_DISP]) |-> $past(status[STG_SYNC]));

    a_r6_pclk_outlives_sync: assert property (@(posedge clk) disable iff (!rst_n)
        status[STG_SYNC] |=> status[STG_PCLK]);

endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis #(
    parameter int LW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          step,
    input  logic [LW-1:0] len_sync,
    input  logic [LW-1:0] len_back,
    input  logic [LW-1:0] len_act,
    input  logic [LW-1:0] len_front,
    output logic          at_origin,
    output logic          wrap,
    output logic          in_sync,
    output logic          in_act
);

    localparam int TW = LW + 2;

    logic [TW-1:0] cnt_q;
    logic [TW-1:0] total;
    logic [TW-1:0] last;
    logic [TW-1:0] act_lo;
    logic [TW-1:0] act_hi;
    logic          at_last;

    assign total   = TW'(len_sync) + TW'(len_back) + TW'(len_act) + TW'(len_front);
    assign last    = total - TW'(1);
    assign at_last = (cnt_q >= last);
    assign act_lo  = TW'(len_sync) + TW'(len_back);
    assign act_hi  = act_lo + TW'(len_act);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= at_last ? '0 : cnt_q + TW'(1);
        end
    end

    assign at_origin = (cnt_q == '0);
    assign wrap      = run && step && at_last;
    assign in_sync   = (cnt_q < TW'(len_sync));
    assign in_act    = (cnt_q >= act_lo) && (cnt_q < act_hi);

    a_r11_idle_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> at_origin);

endmodule

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
    import lcd_tg_pkg::*;
#(
    parameter int FW    = 12,
    parameter int DIV_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [3:0]         addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic [NUM_STG-1:0] status_in,
    input  logic               sof_in,
    output logic [NUM_STG-1:0] en_set,
    output logic [NUM_STG-1:0] en_clr,
    output logic [FW-1:0]      hsw_m1,
    output logic [FW-1:0]      vsw_m1,
    output logic [FW-1:0]      vfp_m1,
    output logic [FW-1:0]      vbp,
    output logic [FW-1:0]      hfp_m1,
    output logic [FW-1:0]      hbp_m1,
    output logic [FW-1:0]      hact_m1,
    output logic [FW-1:0]      vact_m1,
    output logic               hs_low,
    output logic               vs_low,
    output logic [1:0]         mode,
    output logic [DIV_W-1:0]   div,
    output logic               src2x,
    output logic               irq
);

    localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

    logic             mask_q;
    logic             isr_q;
    logic [DIV_W-1:0] div_wr;

    assign div_wr = wdata[8 +: DIV_W];
    assign en_set = (wr && addr == A_EN)  ? wdata[NUM_STG-1:0] : '0;
    assign en_clr = (wr && addr == A_DIS) ? wdata[NUM_STG-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsw_m1  <= '0;
            vsw_m1  <= '0;
            vfp_m1  <= '0;
            vbp     <= '0;
            hfp_m1  <= '0;
            hbp_m1  <= '0;
            hact_m1 <= '0;
            vact_m1 <= '0;
            hs_low  <= 1'b0;
            vs_low  <= 1'b0;
            mode    <= '0;
            div     <= DIV_MIN;
            src2x   <= 1'b0;
        end else if (wr) begin
            case (addr)
                A_CLKCFG: begin
                    src2x <= wdata[0];
                    div   <= (div_wr < DIV_MIN) ? DIV_MIN : div_wr;
                end
                A_SYNCW: begin
                    hsw_m1 <= wdata[FW-1:0];
                    vsw_m1 <= wdata[16 +: FW];
                end
                A_VPORCH: begin
                    vfp_m1 <= wdata[FW-1:0];
                    vbp    <= wdata[16 +: FW];
                end
                A_HPORCH: begin
                    hfp_m1 <= wdata[FW-1:0];
                    hbp_m1 <= wdata[16 +: FW];
                end
                A_ACTIVE: begin
                    hact_m1 <= wdata[FW-1:0];
                    vact_m1 <= wdata[16 +: FW];
                end
                A_POLMOD: begin
                    hs_low <= wdata[0];
                    vs_low <= wdata[1];
                    mode   <= wdata[9:8];
                end
                default: ;
            endcase
        end
    end

    // interrupt mask and status; a new frame start wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
            isr_q  <= 1'b0;
        end else begin
            if (wr && addr == A_IEN && wdata[0])       mask_q <= 1'b1;
            else if (wr && addr == A_IDIS && wdata[0]) mask_q <= 1'b0;
            if (sof_in)                                isr_q  <= 1'b1;
            else if (wr && addr == A_ISR && wdata[0])  isr_q  <= 1'b0;
        end
    end

    assign irq = isr_q & mask_q;

    always_comb begin
        rdata = '0;
        case (addr)
            A_CLKCFG: rdata = (32'(div) << 8) | 32'(src2x);
            A_SYNCW:  rdata = {16'(vsw_m1), 16'(hsw_m1)};
            A_VPORCH: rdata = {16'(vbp), 16'(vfp_m1)};
            A_HPORCH: rdata = {16'(hbp_m1), 16'(hfp_m1)};
            A_ACTIVE: rdata = {16'(vact_m1), 16'(hact_m1)};
            A_POLMOD: rdata = {22'd0, mode, 6'd0, vs_low, hs_low};
            A_STAT:   rdata = 32'(status_in);
            A_IMASK:  rdata = 32'(mask_q);
            A_ISR:    rdata = 32'(isr_q);
            default:  rdata = '0;
        endcase
    end

    a_r10_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
        div >= DIV_MIN);

    a_r9_irq_follows_sof: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_in && mask_q && !(wr && addr == A_IDIS)) |=> irq);

endmodule

// File: rtl/lcd_sync_timing_gen.sv
module lcd_sync_timing_gen
    import lcd_tg_pkg::*;
#(
    parameter int FW    = 12,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [3:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             lcd_hsync,
    output logic             lcd_vsync,
    output logic             lcd_de,
    output logic             frame_start,
    output logic             irq,
    output logic [DIV_W-1:0] pclk_div,
    output logic             pclk_src_2x,
    output logic [1:0]       out_mode
);

    localparam int LW = FW + 1;

    logic [NUM_STG-1:0] status;
    logic [NUM_STG-1:0] en_set;
    logic [NUM_STG-1:0] en_clr;
    logic [FW-1:0] hsw_m1, vsw_m1, vfp_m1, vbp, hfp_m1, hbp_m1, hact_m1, vact_m1;
    logic hs_low, vs_low;
    logic run, disp;
    logic h_org, h_wrap, h_sync, h_act;
    logic v_org, v_wrap, v_sync, v_act;

    lcd_tg_regs #(.FW(FW), .DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .status_in (status),
        .sof_in    (frame_start),
        .en_set    (en_set),
        .en_clr    (en_clr),
        .hsw_m1    (hsw_m1),
        .vsw_m1    (vsw_m1),
        .vfp_m1    (vfp_m1),
        .vbp       (vbp),
        .hfp_m1    (hfp_m1),
        .hbp_m1    (hbp_m1),
        .hact_m1   (hact_m1),
        .vact_m1   (vact_m1),
        .hs_low    (hs_low),
        .vs_low    (vs_low),
        .mode      (out_mode),
        .div       (pclk_div),
        .src2x     (pclk_src_2x),
        .irq       (irq)
    );

    lcd_tg_power u_power (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (en_set),
        .clr_req (en_clr),
        .status  (status)
    );

    assign run  = status[STG_SYNC];
    assign disp = status[STG_DISP];

    lcd_tg_axis #(.LW(LW)) u_h_axis (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .step      (1'b1),
        .len_sync  (LW'(hsw_m1) + LW'(1)),
        .len_back  (LW'(hbp_m1) + LW'(1)),
        .len_act   (LW'(hact_m1) + LW'(1)),
        .len_front (LW'(hfp_m1) + LW'(1)),
        .at_origin (h_org),
        .wrap      (h_wrap),
        .in_sync   (h_sync),
        .in_act    (h_act)
    );

    lcd_tg_axis #(.LW(LW)) u_v_axis (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .step      (h_wrap),
        .len_sync  (LW'(vsw_m1) + LW'(1)),
        .len_back  (LW'(vbp)),
        .len_act   (LW'(vact_m1) + LW'(1)),
        .len_front (LW'(vfp_m1) + LW'(1)),
        .at_origin (v_org),
        .wrap      (v_wrap),
        .in_sync   (v_sync),
        .in_act    (v_act)
    );

    logic unused_v_wrap;
    assign unused_v_wrap = v_wrap;

    assign frame_start = run && h_org && v_org;
    assign lcd_hsync   = (run && h_sync) ^ hs_low;
    assign lcd_vsync   = (run && v_sync) ^ vs_low;
    assign lcd_de      = disp && h_act && v_act;

    a_r8_sof_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    a_r4_de_outside_hsync: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_de |-> (lcd_hsync == hs_low));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!frame_start && !lcd_de));

endmodule

// File: tb/lcd_sync_timing_gen_bench.sv
module lcd_sync_timing_gen_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lcd_hsync, lcd_vsync, lcd_de, frame_start, irq;
    logic [7:0]  pclk_div;
    logic        pclk_src_2x;
    logic [1:0]  out_mode;

    int n_checks = 0;
    int n_err    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_sync_timing_gen u_lcd_sync_timing_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .lcd_hsync   (lcd_hsync),
        .lcd_vsync   (lcd_vsync),
        .lcd_de      (lcd_de),
        .frame_start (frame_start),
        .irq         (irq),
        .pclk_div    (pclk_div),
        .pclk_src_2x (pclk_src_2x),
        .out_mode    (out_mode)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_sof(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (frame_start) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    // expected {hsync, vsync, de, frame_start} from the requirements
    function automatic logic [3:0] model(input int t, input int hs, input int hb, input int ha,
                                         input int hf, input int vs, input int vb, input int va,
                                         input int vf, input bit hp, input bit vp, input bit dsp);
        int ht = hs + hb + ha + hf;
        int vt = vs + vb + va + vf;
        int h  = t % ht;
        int v  = (t / ht) % vt;
        logic hx = (h < hs) ^ hp;
        logic vx = (v < vs) ^ vp;
        logic de = dsp && (h >= hs + hb) && (h < hs + hb + ha) && (v >= vs + vb) && (v < vs + vb + va);
        logic fs = (h == 0) && (v == 0);
        return {hx, vx, de, fs};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_err++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        bit seen;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(4'd8, d);
        check(d == 0, "R1 status", d, 0);
        check({lcd_hsync, lcd_vsync, lcd_de, frame_start, irq} == 5'b0, "R1 outputs",
              {lcd_hsync, lcd_vsync, lcd_de, frame_start, irq}, 0);
        check(pclk_div == 8'd2, "R1 divider", pclk_div, 2);
        peek(4'd12, d);
        check(d == 0, "R1 irq status", d, 0);

        // R5 staged enable, upper stages requested first must wait
        wr(4'd6, 32'b110);
        peek(4'd8, d);
        check(d == 0, "R5 wait for pclk", d, 0);
        wr(4'd6, 32'b001);
        peek(4'd8, d);
        check(d == 32'b001, "R5 pclk up", d, 1);
        @(negedge clk); peek(4'd8, d);
        check(d == 32'b011, "R5 sync up", d, 3);
        @(negedge clk); peek(4'd8, d);
        check(d == 32'b111, "R5 disp up", d, 7);

        // R6 staged disable
        wr(4'd7, 32'b001);
        peek(4'd8, d);
        check(d == 32'b111, "R6 pclk held", d, 7);
        wr(4'd7, 32'b100);
        peek(4'd8, d);
        check(d == 32'b011, "R6 disp down", d, 3);
        wr(4'd7, 32'b010);
        peek(4'd8, d);
        check(d == 32'b001, "R6 sync down", d, 1);
        @(negedge clk); peek(4'd8, d);
        check(d == 32'b000, "R6 pclk follows", d, 0);
        wr(4'd6, 32'b001);

        // R10 divider floor and source select
        wr(4'd0, 32'h100);
        peek(4'd0, d);
        check(pclk_div == 8'd2 && d == 32'h200, "R10 div 1 clamped", d, 32'h200);
        wr(4'd0, 32'h000);
        check(pclk_div == 8'd2, "R10 div 0 clamped", pclk_div, 2);
        wr(4'd0, 32'h901);
        check(pclk_div == 8'd9 && pclk_src_2x, "R10 div 9 src2x", {pclk_src_2x, pclk_div}, 32'h109);

        // random configurations
        for (int k = 0; k < 10; k++) begin
            int hsf = $urandom_range(0, 4), hbf = $urandom_range(0, 4);
            int haf = $urandom_range(0, 4), hff = $urandom_range(0, 4);
            int vsf = $urandom_range(0, 4), vbf = $urandom_range(0, 3);
            int vaf = $urandom_range(0, 4), vff = $urandom_range(0, 4);
            bit hp = 1'($urandom_range(0, 1)), vp = 1'($urandom_range(0, 1));
            logic [1:0] md = 2'($urandom_range(0, 3));
            int ht, vt, bad;
            logic [3:0] got, exp, bad_got, bad_exp;
            if (k == 0) begin
                hsf = 0; hbf = 0; haf = 0; hff = 0; vsf = 0; vbf = 0; vaf = 0; vff = 0;
            end
            ht = hsf + hbf + haf + hff + 4;
            vt = vsf + vbf + vaf + vff + 3;
            wr(4'd7, 32'b100);
            wr(4'd7, 32'b010);
            wr(4'd1, (32'(vsf) << 16) | 32'(hsf));
            wr(4'd2, (32'(vbf) << 16) | 32'(vff));
            wr(4'd3, (32'(hbf) << 16) | 32'(hff));
            wr(4'd4, (32'(vaf) << 16) | 32'(haf));
            wr(4'd5, (32'(md) << 8) | (32'(vp) << 1) | 32'(hp));
            // R7 / R11 idle levels
            check({lcd_hsync, lcd_vsync, frame_start, lcd_de} == {hp, vp, 2'b00}, "R7 R11 idle",
                  {lcd_hsync, lcd_vsync, frame_start, lcd_de}, {hp, vp, 2'b00});
            check(out_mode == md, "R10 out_mode", out_mode, md);
            peek(4'd2, d);
            check(d == ((32'(vbf) << 16) | 32'(vff)), "R2 readback", d, (32'(vbf) << 16) | 32'(vff));
            // R8 restart at origin when sync comes up
            wr(4'd6, 32'b010);
            exp = model(0, hsf + 1, hbf + 1, haf + 1, hff + 1, vsf + 1, vbf, vaf + 1, vff + 1, hp, vp, 1'b0);
            got = {lcd_hsync, lcd_vsync, lcd_de, frame_start};
            check(got == exp, "R8 R11 first cycle", got, exp);
            wr(4'd6, 32'b100);
            wait_sof(seen);
            check(seen, "R8 frame_start seen", 32'(seen), 1);
            bad = 0; bad_got = '0; bad_exp = '0;
            for (int t = 0; t < 2 * ht * vt; t++) begin
                exp = model(t, hsf + 1, hbf + 1, haf + 1, hff + 1, vsf + 1, vbf, vaf + 1, vff + 1, hp, vp, 1'b1);
                got = {lcd_hsync, lcd_vsync, lcd_de, frame_start};
                if (got != exp && bad == 0) begin
                    bad = 1; bad_got = got; bad_exp = exp;
                end
                @(negedge clk);
            end
            check(bad == 0, "R3 R4 R8 frame timing", bad_got, bad_exp);
        end

        // R9 interrupt
        wr(4'd9, 32'd1);
        peek(4'd11, d);
        check(d == 1, "R9 mask set", d, 1);
        wait_sof(seen);
        @(negedge clk);
        check(irq == 1'b1, "R9 irq after sof", irq, 1);
        wr(4'd12, 32'd1);
        check(irq == 1'b0, "R9 irq cleared", irq, 0);
        wr(4'd10, 32'd1);
        wait_sof(seen);
        @(negedge clk);
        peek(4'd12, d);
        check(irq == 1'b0 && d == 1, "R9 masked status", {irq, d[0]}, 1);

        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule